// File: doc/BRIEF.md
# Serial adder-subtractor accumulator

This block adds a 4-bit operand into a 4-bit accumulator, or subtracts it, one bit pair per clock, least significant bit first. An operand register and the accumulator are both shift registers. A single full-adder stage combines their low bits with a stored carry. Each sum bit is pushed back into the accumulator from its top end. The operand register rotates, so after a pass it holds the same value again. One pass takes four shift clocks.

A mode bit chooses the operation. For subtraction the operand stream is inverted and the carry starts at one, which forms the two's complement of the operand. The carry flag is kept after each pass. Several passes can therefore be chained: with a chain request, the next pass starts from the stored carry rather than from the mode's default seed. A busy flag covers the pass, and a one-cycle done pulse marks its end.

Top module: `ser_addsub_acc`

## Requirements
- R1: While `rst` is high at a clock edge, `acc`, `carry`, `busy` and `done` become 0.
- R2: When idle (`busy`=0), `load_a` copies `a_in` into the accumulator and `load_b` copies `b_in` into the operand register at the next edge.
- R3: A `start` accepted at edge k (idle, no load in that cycle) raises `busy` after edge k. `busy` stays high through edge k+4 and falls there. `done` is high for exactly the one cycle after edge k+4.
- R4: With `mode`=0 (add) and no chaining, a pass leaves {`carry`,`acc`} = A + B.
- R5: With `mode`=1 (subtract) and no chaining, a pass leaves `acc` = (A − B) mod 16, with `carry`=1 when A ≥ B and 0 when a borrow occurs.
- R6: Without `chain`, the carry is seeded with 0 for add and 1 for subtract. With `chain`=1, the pass starts from the carry flag left by the previous pass.
- R7: `acc` and `carry` hold their values between passes. Starting from 5, adding 6 and then 15 leaves `acc`=4'b1010 with `carry`=1.
- R8: Starting from 15 and subtracting 4, then 5, then 13 leaves `acc`=4'b1001 with `carry`=0.
- R9: After a pass the operand register holds its value again, so a second `start` without reloading adds the same operand again.
- R10: While `busy`=1, `start`, `load_a`, `load_b` and changes of `mode` have no effect on the pass in progress or on the operand register.
- R11: A `start` in the same cycle as `load_a` or `load_b` is ignored: the load takes place and `busy` stays 0.
- R12: The bits are processed least significant first, and each sum bit enters `acc` at bit 3. Adding B=1 to A=0 gives `acc`=4'b1000 after the first shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 = add, 1 = subtract; sampled when start is accepted |
| chain | input | 1 | 1 = seed the carry from the stored flag |
| load_a | input | 1 | Load `a_in` into the accumulator when idle |
| load_b | input | 1 | Load `b_in` into the operand register when idle |
| a_in | input | 4 | Accumulator load value |
| b_in | input | 4 | Operand load value |
| start | input | 1 | Begin a serial pass |
| acc | output | 4 | Accumulator contents |
| carry | output | 1 | Carry / no-borrow flag |
| busy | output | 1 | Serial pass in progress |
| done | output | 1 | One-cycle pulse when a pass finishes |

## Verification
The checker assumes that all inputs are synchronous to the clock. It also assumes that reset is high at the first edge, so the idle-hold and seeding properties start from a defined state. Its reference result is captured from the accumulator, operand register, carry flag, mode and chain at the edge where start is accepted. It is then compared when done rises, so it relies on the operand register not being disturbed in between. The stimulus changes inputs only at falling clock edges and holds reset for several cycles before any activity. It also deliberately drives loads, start and mode during a pass, to show that these are blocked.

// File: rtl/ser_acc_pkg.sv
package ser_acc_pkg;

    localparam int unsigned ACC_W_DEF = 4;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_mode_e;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic sum;
        logic cout;
    } bit_res_t;

    // One bit time: the operand bit is inverted for subtraction.
    function automatic bit_res_t serial_fa(logic a, logic b, logic cin, op_mode_e m);
        bit_res_t r;
        logic     bx;
        bx     = b ^ (m == OP_SUB);
        r.sum  = a ^ bx ^ cin;
        r.cout = (a & bx) | (a & cin) | (bx & cin);
        return r;
    endfunction

    // Carry value at the start of a pass.
    function automatic logic carry_seed(op_mode_e m, logic keep, logic held);
        return keep ? held : (m == OP_SUB);
    endfunction

endpackage

// File: rtl/ser_shreg.sv
module ser_shreg #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         ser_in,
    output logic [W-1:0] q
);
    logic [W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
        end else if (load) begin
            q_r <= load_val;
        end else if (shift) begin
            q_r <= {ser_in, q_r[W-1:1]};
        end
    end

    assign q = q_r;
endmodule

// File: rtl/ser_bit_stage.sv
module ser_bit_stage
    import ser_acc_pkg::*;
(
    input  logic     a_bit,
    input  logic     b_bit,
    input  logic     cin,
    input  op_mode_e op,
    output bit_res_t res
);
    always_comb begin
        res = serial_fa(a_bit, b_bit, cin, op);
    end
endmodule

// File: rtl/ser_seq_ctrl.sv
module ser_seq_ctrl
    import ser_acc_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic busy,
    output logic done
);
    localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(W - 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic             last;

    assign last = (cnt_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (go) begin
                        state_q <= SQ_RUN;
                        cnt_q   <= '0;
                    end
                end
                SQ_RUN: begin
                    cnt_q <= cnt_q + CNT_W'(1);
                    if (last) begin
                        state_q <= SQ_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign busy = (state_q == SQ_RUN);
    assign done = done_q;
endmodule

// File: rtl/ser_addsub_acc.sv
module ser_addsub_acc
    import ser_acc_pkg::*;
#(
    parameter int unsigned W = ACC_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mode,
    input  logic         chain,
    input  logic         load_a,
    input  logic         load_b,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         start,
    output logic [W-1:0] acc,
    output logic         carry,
    output logic         busy,
    output logic         done
);
    logic         busy_w;
    logic         go;
    logic         ld_a;
    logic         ld_b;
    logic [W-1:0] a_q;
    logic [W-1:0] b_q;
    logic         carry_q;
    op_mode_e     op_q;
    bit_res_t     step;

    assign ld_a = load_a & ~busy_w;
    assign ld_b = load_b & ~busy_w;
    assign go   = start & ~busy_w & ~load_a & ~load_b;

    ser_seq_ctrl #(.W(W)) u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .go   (go),
        .busy (busy_w),
        .done (done)
    );

    ser_bit_stage u_stage (
        .a_bit (a_q[0]),
        .b_bit (b_q[0]),
        .cin   (carry_q),
        .op    (op_q),
        .res   (step)
    );

    // Accumulator: the sum bit enters at the top.
    ser_shreg #(.W(W)) u_areg (
        .clk      (clk),
        .rst      (rst),
        .load     (ld_a),
        .load_val (a_in),
        .shift    (busy_w),
        .ser_in   (step.sum),
        .q        (a_q)
    );

    // Operand: rotates, so it is intact after W shifts.
    ser_shreg #(.W(W)) u_breg (
        .clk      (clk),
        .rst      (rst),
        .load     (ld_b),
        .load_val (b_in),
        .shift    (busy_w),
        .ser_in   (b_q[0]),
        .q        (b_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q    <= OP_ADD;
            carry_q <= 1'b0;
        end else if (go) begin
            op_q    <= op_mode_e'(mode);
            carry_q <= carry_seed(op_mode_e'(mode), chain, carry_q);
        end else if (busy_w) begin
            carry_q <= step.cout;
        end
    end

    assign acc   = a_q;
    assign carry = carry_q;
    assign busy  = busy_w;
endmodule

// File: rtl/ser_addsub_acc_chk.sv
module ser_addsub_acc_chk #(
    parameter int unsigned W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         mode,
    input logic         chain,
    input logic         load_a,
    input logic         load_b,
    input logic         start,
    input logic [W-1:0] acc,
    input logic         carry,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] b_reg
);
    logic         acc_ok;
    logic [W:0]   exp_q;
    int unsigned  len_q;
    logic         cin_ref;
    logic [W-1:0] bop_ref;

    assign acc_ok  = start && !busy && !load_a && !load_b;
    assign cin_ref = chain ? carry : mode;
    assign bop_ref = mode ? ~b_reg : b_reg;

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_q <= '0;
            len_q <= 0;
        end else if (acc_ok) begin
            exp_q <= {1'b0, acc} + {1'b0, bop_ref} + {{W{1'b0}}, cin_ref};
            len_q <= 0;
        end else if (busy) begin
            len_q <= len_q + 1;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!busy && !done && !carry && acc == '0));

    p_start_busy_r3: assert property (@(posedge clk) disable iff (rst)
        acc_ok |=> busy);

    p_pass_len_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (len_q == W && !busy));

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_result_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> ({carry, acc} == exp_q));

    p_seed_r6: assert property (@(posedge clk) disable iff (rst)
        (acc_ok && !chain) |=> (carry == $past(mode)));

    p_idle_acc_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !load_a) |=> $stable(acc));

    p_idle_carry_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !acc_ok) |=> $stable(carry));
endmodule

bind ser_addsub_acc ser_addsub_acc_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode),
    .chain  (chain),
    .load_a (load_a),
    .load_b (load_b),
    .start  (start),
    .acc    (acc),
    .carry  (carry),
    .busy   (busy),
    .done   (done),
    .b_reg  (b_q)
);

// File: tb/ser_addsub_acc_tb.sv
`timescale 1ns/1ps
module ser_addsub_acc_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode = 1'b0;
    logic       chain = 1'b0;
    logic       load_a = 1'b0;
    logic       load_b = 1'b0;
    logic [3:0] a_in = '0;
    logic [3:0] b_in = '0;
    logic       start = 1'b0;
    logic [3:0] acc;
    logic       carry;
    logic       busy;
    logic       done;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ser_addsub_acc u_dut (
        .clk(clk), .rst(rst), .mode(mode), .chain(chain),
        .load_a(load_a), .load_b(load_b), .a_in(a_in), .b_in(b_in),
        .start(start), .acc(acc), .carry(carry), .busy(busy), .done(done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load(input logic la, input logic [3:0] av, input logic lb, input logic [3:0] bv);
        @(negedge clk);
        load_a = la; a_in = av; load_b = lb; b_in = bv;
        @(negedge clk);
        load_a = 1'b0; load_b = 1'b0;
    endtask

    task automatic run_op(input logic m, input logic ch);
        @(negedge clk);
        mode = m; chain = ch; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R3 busy after start", busy, 1);
        repeat (3) @(negedge clk);
        chk("R3 busy held", busy, 1);
        chk("R3 done not early", done, 0);
        @(negedge clk);
        chk("R3 done pulse", done, 1);
        chk("R3 busy fallen", busy, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 acc", acc, 0);
        chk("R1 carry", carry, 0);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
    endtask

    task automatic t_add_chain;
        load(1, 4'd5, 1, 4'd6);
        chk("R2 acc loaded", acc, 5);
        run_op(0, 0);
        chk("R4 5+6 acc", acc, 11);
        chk("R4 5+6 carry", carry, 0);
        load(0, 0, 1, 4'd15);
        chk("R7 acc held across load of B", acc, 11);
        run_op(0, 0);
        chk("R7 acc 26", acc, 4'b1010);
        chk("R7 carry 26", carry, 1);
        @(negedge clk);
        chk("R3 done one cycle", done, 0);
        chk("R7 carry held idle", carry, 1);
    endtask

    task automatic t_sub_chain;
        load(1, 4'd15, 1, 4'd4);
        run_op(1, 0);
        chk("R5 15-4 acc", acc, 11);
        chk("R5 15-4 carry", carry, 1);
        load(0, 0, 1, 4'd5);
        run_op(1, 0);
        chk("R5 11-5 acc", acc, 6);
        load(0, 0, 1, 4'd13);
        run_op(1, 0);
        chk("R8 final acc", acc, 4'b1001);
        chk("R8 borrow carry", carry, 0);
    endtask

    task automatic t_seed;
        load(1, 4'd3, 1, 4'd2);
        run_op(0, 0);
        chk("R6 add seed 0", acc, 5);
        load(1, 4'd15, 1, 4'd1);
        run_op(0, 0);
        chk("R6 wrap acc", acc, 0);
        chk("R6 wrap carry", carry, 1);
        load(1, 4'd2, 1, 4'd3);
        run_op(0, 1);
        chk("R6 chained add acc", acc, 6);
        chk("R6 chained add carry", carry, 0);
        load(1, 4'd7, 1, 4'd2);
        run_op(1, 1);
        chk("R6 chained sub acc", acc, 4);
        chk("R6 chained sub carry", carry, 1);
    endtask

    task automatic t_b_reuse;
        load(1, 4'd1, 1, 4'd3);
        run_op(0, 0);
        run_op(0, 0);
        chk("R9 operand reused", acc, 7);
        chk("R9 carry", carry, 0);
    endtask

    task automatic t_busy_ignore;
        load(1, 4'd2, 1, 4'd3);
        @(negedge clk);
        mode = 1'b0; chain = 1'b0; start = 1'b1;
        @(negedge clk);
        chk("R10 busy", busy, 1);
        load_a = 1'b1; a_in = 4'd15; load_b = 1'b1; b_in = 4'd15; mode = 1'b1;
        repeat (4) @(negedge clk);
        start = 1'b0; load_a = 1'b0; load_b = 1'b0; mode = 1'b0;
        chk("R10 done", done, 1);
        chk("R10 acc unaffected", acc, 5);
        chk("R10 carry unaffected", carry, 0);
        run_op(0, 0);
        chk("R10 operand unaffected", acc, 8);
    endtask

    task automatic t_start_load;
        @(negedge clk);
        start = 1'b1; load_a = 1'b1; a_in = 4'd9;
        @(negedge clk);
        start = 1'b0; load_a = 1'b0;
        chk("R11 no pass", busy, 0);
        chk("R11 load taken", acc, 9);
        @(negedge clk);
        chk("R11 still idle", busy, 0);
    endtask

    task automatic t_order;
        load(1, 4'd0, 1, 4'd1);
        @(negedge clk);
        mode = 1'b0; chain = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R12 first sum bit at top", acc, 4'b1000);
        repeat (3) @(negedge clk);
        chk("R12 final", acc, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_add_chain();
        t_sub_chain();
        t_seed();
        t_b_reuse();
        t_busy_ignore();
        t_start_load();
        t_order();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule